// File: doc/BRIEF.md
# Core Power-Domain Sequencer

This block brings a single processor core into and out of its switchable power domain. A one-cycle power-up or power-down command starts a fixed sequence. The sequence drives the core's two active-low reset lines, the execution-width select bit, the output isolation clamp and the debug power-up indication. At one fixed point in each sequence, the block asks an external ramp controller to switch the domain's supply on or off, and it holds that request until the controller answers with a done pulse.

Each reset, clamp and debug step is followed by a settle wait. The wait is 10 or 20 time units, depending on the step. The length of one unit comes from the `unitLen` input: one unit lasts `unitLen + 1` clock cycles. The input must stay steady while a sequence runs.

After system reset the core is powered down:
- the clamp is active and both resets are asserted;
- the debug indication and the width bit are low.

The width bit is set before the supply is switched on and stays set after a power-down. The power-on reset is released during power-up and is not asserted again by power-down. Busy, a one-cycle completion pulse and a powered status bit report progress.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset, the outputs hold these values: clampEn=1, coreRstN=0, porRstN=0, aa64Sel=0, dbgPwrUp=0, swOnReq=0, swOffReq=0, busy=0, seqDone=0, powered=0.
- R2: The block accepts upReq only while idle with powered=0, and downReq only while idle with powered=1. A command of the other kind while idle is ignored: busy does not rise and no output moves. busy rises on the clock edge that samples an accepted command.
- R3: Power-up order, where S(N) = N·(unitLen+1)+2 cycles:
  - Core reset is driven low on the edge after acceptance.
  - Power-on reset is driven low S(10) cycles later.
  - After the switch handshake, the clamp is released on the edge after swOnReq falls.
  - Power-on reset is released S(20) after the clamp release.
  - Core reset is released S(10) after that.
  - dbgPwrUp rises S(10) after the core reset release.
  - dbgPwrUp is high only while both resets are released and the clamp is off.
- R4: During power-up, aa64Sel is set to 1 S(10) cycles after power-on reset is asserted. swOnReq rises one cycle later. swOnReq stays high until the edge that samples swDone=1 and falls on that edge.
- R5: Power-down order:
  - dbgPwrUp falls on the edge after acceptance.
  - The clamp is applied S(10) later.
  - Core reset is driven low S(20) after that.
  - swOffReq rises S(10) after that and is held until the edge that samples swDone=1.
  - Afterwards porRstN=1 and aa64Sel=1 remain.
- R6: Every settle wait lasts N·(unitLen+1) cycles, with N=20 after a clamp change and N=10 after every other reset or debug step. Two extra cycles separate the edge that starts a wait from the edge that applies the next step.
- R7: upReq and downReq are ignored while busy=1. The sequence timing is unchanged and exactly one completion follows.
- R8: swDone is ignored when no switch request is outstanding.
- R9: Completion reporting:
  - seqDone is a single-cycle pulse.
  - seqDone, the fall of busy and the update of powered happen on the same edge.
  - For power-up this edge is S(10)−1 cycles after dbgPwrUp rises.
  - For power-down it is the edge that samples swDone=1.
  - powered changes at no other time.
- R10: swOnReq and swOffReq are never high together. A switch request is raised only with the clamp active and core reset asserted. For swOnReq, power-on reset must also be asserted; for swOffReq, dbgPwrUp must also be low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upReq | input | 1 | Power-up command, one cycle |
| downReq | input | 1 | Power-down command, one cycle |
| unitLen | input | UNIT_W | Cycles per settle unit minus one |
| swDone | input | 1 | Ramp controller completion pulse |
| swOnReq | output | 1 | Request to switch domain supply on |
| swOffReq | output | 1 | Request to switch domain supply off |
| coreRstN | output | 1 | Core reset, low holds the core in reset |
| porRstN | output | 1 | Power-on reset, low asserts |
| aa64Sel | output | 1 | Execution-width select, 1 = 64-bit |
| clampEn | output | 1 | Output isolation clamp, 1 = clamped |
| dbgPwrUp | output | 1 | Debug power-up indication |
| busy | output | 1 | A sequence is in progress |
| seqDone | output | 1 | One-cycle pulse when a sequence ends |
| powered | output | 1 | Core domain is on |

## Verification
The bench times every output edge against the start of busy, under several unit lengths and several ramp-controller latencies. An off-by-one in the settle prescaler, a swapped 10/20 step, or a lost hand-off cycle therefore shows up as a wrong cycle distance.

It injects commands of both kinds while a sequence runs, and a stray swDone during a timer wait. A design that restarted, aborted or advanced on these would show shifted edges or a second completion pulse.

It also issues the wrong command while idle, and powers up a second time from the state power-down leaves behind, where power-on reset is visibly reasserted. A design that acted on the wrong command, or that left an output at the wrong level after power-down, fails there.

// File: rtl/core_pwr_pkg.sv
package core_pwr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP_CORE,
    ST_UP_POR,
    ST_UP_MODE,
    ST_UP_SWITCH,
    ST_UP_UNCLAMP,
    ST_UP_POR_REL,
    ST_UP_CORE_REL,
    ST_UP_DBG,
    ST_DN_DBG,
    ST_DN_CLAMP,
    ST_DN_CORE,
    ST_DN_SWITCH
  } stepE;

  typedef enum logic {PH_ACT, PH_WAIT} phaseE;

  // Strobes from the sequencer control to the output datapath.
  typedef struct packed {
    logic coreHold;
    logic coreFree;
    logic porHold;
    logic porFree;
    logic modeWide;
    logic clampOn;
    logic clampOff;
    logic dbgOn;
    logic dbgOff;
    logic swOnRaise;
    logic swOffRaise;
    logic swDrop;
    logic settleLoad;
    logic settleLong;
  } strobeS;

  function automatic stepE stepAfter(input stepE s);
    case (s)
      ST_UP_CORE:     return ST_UP_POR;
      ST_UP_POR:      return ST_UP_MODE;
      ST_UP_MODE:     return ST_UP_SWITCH;
      ST_UP_SWITCH:   return ST_UP_UNCLAMP;
      ST_UP_UNCLAMP:  return ST_UP_POR_REL;
      ST_UP_POR_REL:  return ST_UP_CORE_REL;
      ST_UP_CORE_REL: return ST_UP_DBG;
      ST_DN_DBG:      return ST_DN_CLAMP;
      ST_DN_CLAMP:    return ST_DN_CORE;
      ST_DN_CORE:     return ST_DN_SWITCH;
      default:        return ST_IDLE;
    endcase
  endfunction

  function automatic logic isSwitchStep(input stepE s);
    return (s == ST_UP_SWITCH) || (s == ST_DN_SWITCH);
  endfunction

  function automatic logic hasSettle(input stepE s);
    return !(s == ST_IDLE || s == ST_UP_MODE || isSwitchStep(s));
  endfunction

  // Action of each step, applied in its single act cycle.
  function automatic strobeS actStrobes(input stepE s);
    strobeS st;
    st = '0;
    case (s)
      ST_UP_CORE:     begin st.coreHold = 1'b1;  st.settleLoad = 1'b1; end
      ST_UP_POR:      begin st.porHold = 1'b1;   st.settleLoad = 1'b1; end
      ST_UP_MODE:     st.modeWide = 1'b1;
      ST_UP_SWITCH:   st.swOnRaise = 1'b1;
      ST_UP_UNCLAMP:  begin st.clampOff = 1'b1;  st.settleLoad = 1'b1; st.settleLong = 1'b1; end
      ST_UP_POR_REL:  begin st.porFree = 1'b1;   st.settleLoad = 1'b1; end
      ST_UP_CORE_REL: begin st.coreFree = 1'b1;  st.settleLoad = 1'b1; end
      ST_UP_DBG:      begin st.dbgOn = 1'b1;     st.settleLoad = 1'b1; end
      ST_DN_DBG:      begin st.dbgOff = 1'b1;    st.settleLoad = 1'b1; end
      ST_DN_CLAMP:    begin st.clampOn = 1'b1;   st.settleLoad = 1'b1; st.settleLong = 1'b1; end
      ST_DN_CORE:     begin st.coreHold = 1'b1;  st.settleLoad = 1'b1; end
      ST_DN_SWITCH:   st.swOffRaise = 1'b1;
      default:        st = '0;
    endcase
    return st;
  endfunction

endpackage

// File: rtl/core_pwr_settle.sv
module core_pwr_settle #(
  parameter int UNIT_W      = 8,
  parameter int SHORT_UNITS = 10,
  parameter int LONG_UNITS  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              longSel,
  input  logic [UNIT_W-1:0] unitLen,
  output logic              idle
);
  localparam int MAX_UNITS = (LONG_UNITS > SHORT_UNITS) ? LONG_UNITS : SHORT_UNITS;
  localparam int CNT_W     = $clog2(MAX_UNITS + 1);

  logic [CNT_W-1:0]  unitsQ;
  logic [UNIT_W-1:0] tickQ;
  logic [UNIT_W-1:0] lenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unitsQ <= '0;
      tickQ  <= '0;
      lenQ   <= '0;
    end else if (load) begin
      unitsQ <= longSel ? CNT_W'(LONG_UNITS) : CNT_W'(SHORT_UNITS);
      tickQ  <= unitLen;
      lenQ   <= unitLen;
    end else if (unitsQ != '0) begin
      if (tickQ == '0) begin
        tickQ  <= lenQ;
        unitsQ <= unitsQ - 1'b1;
      end else begin
        tickQ <= tickQ - 1'b1;
      end
    end
  end

  assign idle = (unitsQ == '0);

endmodule

// File: rtl/core_pwr_dp.sv
module core_pwr_dp
  import core_pwr_pkg::*;
#(
  parameter int UNIT_W      = 8,
  parameter int SHORT_UNITS = 10,
  parameter int LONG_UNITS  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeS            stb,
  input  logic [UNIT_W-1:0] unitLen,
  output logic              settleIdle,
  output logic              swOnReq,
  output logic              swOffReq,
  output logic              coreRstN,
  output logic              porRstN,
  output logic              aa64Sel,
  output logic              clampEn,
  output logic              dbgPwrUp
);
  logic coreQ, porQ, modeQ, clampQ, dbgQ, swOnQ, swOffQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreQ  <= 1'b0;
      porQ   <= 1'b0;
      modeQ  <= 1'b0;
      clampQ <= 1'b1;
      dbgQ   <= 1'b0;
      swOnQ  <= 1'b0;
      swOffQ <= 1'b0;
    end else begin
      if (stb.coreHold)      coreQ <= 1'b0;
      else if (stb.coreFree) coreQ <= 1'b1;

      if (stb.porHold)       porQ <= 1'b0;
      else if (stb.porFree)  porQ <= 1'b1;

      if (stb.modeWide)      modeQ <= 1'b1;

      if (stb.clampOn)       clampQ <= 1'b1;
      else if (stb.clampOff) clampQ <= 1'b0;

      if (stb.dbgOn)         dbgQ <= 1'b1;
      else if (stb.dbgOff)   dbgQ <= 1'b0;

      if (stb.swDrop) begin
        swOnQ  <= 1'b0;
        swOffQ <= 1'b0;
      end else begin
        if (stb.swOnRaise)  swOnQ  <= 1'b1;
        if (stb.swOffRaise) swOffQ <= 1'b1;
      end
    end
  end

  core_pwr_settle #(
    .UNIT_W     (UNIT_W),
    .SHORT_UNITS(SHORT_UNITS),
    .LONG_UNITS (LONG_UNITS)
  ) u_settle (
    .clk    (clk),
    .rstN   (rstN),
    .load   (stb.settleLoad),
    .longSel(stb.settleLong),
    .unitLen(unitLen),
    .idle   (settleIdle)
  );

  assign coreRstN = coreQ;
  assign porRstN  = porQ;
  assign aa64Sel  = modeQ;
  assign clampEn  = clampQ;
  assign dbgPwrUp = dbgQ;
  assign swOnReq  = swOnQ;
  assign swOffReq = swOffQ;

endmodule

// File: rtl/core_pwr_ctrl.sv
module core_pwr_ctrl
  import core_pwr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   upReq,
  input  logic   downReq,
  input  logic   settleIdle,
  input  logic   swDone,
  output strobeS stb,
  output logic   busy,
  output logic   seqDone,
  output logic   powered
);
  stepE  stepQ, stepD;
  phaseE phaseQ, phaseD;
  logic  poweredQ, doneQ, finish, advance;

  always_comb begin
    stb     = '0;
    stepD   = stepQ;
    phaseD  = phaseQ;
    finish  = 1'b0;
    advance = 1'b0;
    if (stepQ == ST_IDLE) begin
      phaseD = PH_ACT;
      if (upReq && !poweredQ)       stepD = ST_UP_CORE;
      else if (downReq && poweredQ) stepD = ST_DN_DBG;
    end else if (phaseQ == PH_ACT) begin
      stb = actStrobes(stepQ);
      if (isSwitchStep(stepQ) || hasSettle(stepQ)) phaseD = PH_WAIT;
      else stepD = stepAfter(stepQ);
    end else begin
      advance    = isSwitchStep(stepQ) ? swDone : settleIdle;
      stb.swDrop = advance && isSwitchStep(stepQ);
      if (advance) begin
        stepD  = stepAfter(stepQ);
        phaseD = PH_ACT;
        finish = (stepAfter(stepQ) == ST_IDLE);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ    <= ST_IDLE;
      phaseQ   <= PH_ACT;
      poweredQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      stepQ  <= stepD;
      phaseQ <= phaseD;
      doneQ  <= finish;
      if (finish) poweredQ <= (stepQ == ST_UP_DBG);
    end
  end

  assign busy    = (stepQ != ST_IDLE);
  assign seqDone = doneQ;
  assign powered = poweredQ;

endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
  import core_pwr_pkg::*;
#(
  parameter int UNIT_W      = 8,
  parameter int SHORT_UNITS = 10,
  parameter int LONG_UNITS  = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upReq,
  input  logic              downReq,
  input  logic [UNIT_W-1:0] unitLen,
  input  logic              swDone,
  output logic              swOnReq,
  output logic              swOffReq,
  output logic              coreRstN,
  output logic              porRstN,
  output logic              aa64Sel,
  output logic              clampEn,
  output logic              dbgPwrUp,
  output logic              busy,
  output logic              seqDone,
  output logic              powered
);
  strobeS stb;
  logic   settleIdle;

  core_pwr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .upReq     (upReq),
    .downReq   (downReq),
    .settleIdle(settleIdle),
    .swDone    (swDone),
    .stb       (stb),
    .busy      (busy),
    .seqDone   (seqDone),
    .powered   (powered)
  );

  core_pwr_dp #(
    .UNIT_W     (UNIT_W),
    .SHORT_UNITS(SHORT_UNITS),
    .LONG_UNITS (LONG_UNITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .unitLen   (unitLen),
    .settleIdle(settleIdle),
    .swOnReq   (swOnReq),
    .swOffReq  (swOffReq),
    .coreRstN  (coreRstN),
    .porRstN   (porRstN),
    .aa64Sel   (aa64Sel),
    .clampEn   (clampEn),
    .dbgPwrUp  (dbgPwrUp)
  );

endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk (
  input logic clk,
  input logic rstN,
  input logic swDone,
  input logic swOnReq,
  input logic swOffReq,
  input logic coreRstN,
  input logic porRstN,
  input logic aa64Sel,
  input logic clampEn,
  input logic dbgPwrUp,
  input logic busy,
  input logic seqDone,
  input logic powered
);
  AST_SW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(swOnReq && swOffReq)); // R10
  AST_SW_ON_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    swOnReq |-> (clampEn && !coreRstN && !porRstN)); // R10
  AST_SW_OFF_SAFE: assert property (@(posedge clk) disable iff (!rstN)
    swOffReq |-> (clampEn && !coreRstN && !dbgPwrUp)); // R10
  AST_MODE_BEFORE_SW: assert property (@(posedge clk) disable iff (!rstN)
    swOnReq |-> aa64Sel); // R4
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (swOnReq && !swDone) |=> swOnReq); // R4
  AST_DBG_LIVE_CORE: assert property (@(posedge clk) disable iff (!rstN)
    dbgPwrUp |-> (coreRstN && porRstN && !clampEn)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !busy); // R9
  AST_POWERED_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (powered != $past(powered)) |-> seqDone); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable({clampEn, coreRstN, porRstN, dbgPwrUp, aa64Sel})); // R2
endmodule

bind core_pwr_seq core_pwr_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .swDone  (swDone),
  .swOnReq (swOnReq),
  .swOffReq(swOffReq),
  .coreRstN(coreRstN),
  .porRstN (porRstN),
  .aa64Sel (aa64Sel),
  .clampEn (clampEn),
  .dbgPwrUp(dbgPwrUp),
  .busy    (busy),
  .seqDone (seqDone),
  .powered (powered)
);

// File: tb/core_pwr_seq_tb.sv
`timescale 1ns/1ps
module core_pwr_seq_tb;
  localparam int UW   = 8;
  localparam int NOUT = 10;
  localparam int O_BUSY = 0, O_SWON = 1, O_SWOFF = 2, O_CORE = 3, O_POR = 4;
  localparam int O_MODE = 5, O_CLAMP = 6, O_DBG = 7, O_DONE = 8, O_PWR = 9;

  logic clk = 1'b0, rstN = 1'b0, upReq = 1'b0, downReq = 1'b0, swDone = 1'b0;
  logic [UW-1:0] unitLen = '0;
  logic swOnReq, swOffReq, coreRstN, porRstN, aa64Sel, clampEn, dbgPwrUp;
  logic busy, seqDone, powered;

  core_pwr_seq #(.UNIT_W(UW)) u_dut (
    .clk(clk), .rstN(rstN), .upReq(upReq), .downReq(downReq), .unitLen(unitLen),
    .swDone(swDone), .swOnReq(swOnReq), .swOffReq(swOffReq), .coreRstN(coreRstN),
    .porRstN(porRstN), .aa64Sel(aa64Sel), .clampEn(clampEn), .dbgPwrUp(dbgPwrUp),
    .busy(busy), .seqDone(seqDone), .powered(powered)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0, swLat = 0;
  bit finished = 1'b0, monOn = 1'b0;
  logic [NOUT-1:0] outs, prevOuts;
  int riseCyc[NOUT];
  int fallCyc[NOUT];
  int riseCnt[NOUT];

  assign outs = {powered, seqDone, dbgPwrUp, clampEn, aa64Sel, porRstN, coreRstN,
                 swOffReq, swOnReq, busy};

  // Edge recorder: cycle index of the latest rise and fall of each output.
  initial begin
    for (int i = 0; i < NOUT; i++) begin
      riseCyc[i] = 0; fallCyc[i] = 0; riseCnt[i] = 0;
    end
    wait (monOn);
    prevOuts = outs;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NOUT; i++) begin
        if (outs[i] && !prevOuts[i]) begin
          riseCyc[i] = cyc; riseCnt[i]++;
        end else if (!outs[i] && prevOuts[i]) begin
          fallCyc[i] = cyc;
        end
      end
      prevOuts = outs;
    end
  end

  // Ramp controller model: answers a switch request after swLat cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (swOnReq || swOffReq)) begin
        repeat (swLat) @(negedge clk);
        swDone = 1'b1;
        @(negedge clk);
        swDone = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input bit noisy);
    int k = 0;
    while (!seqDone && k < 5000) begin
      @(negedge clk);
      k++;
      if (noisy) begin
        upReq   = busy && (k % 11 == 5);
        downReq = busy && (k % 7 == 3);
        if (k == 10) swDone = 1'b1;
        if (k == 11) swDone = 1'b0;
      end
    end
    upReq = 1'b0; downReq = 1'b0;
    chk("R9 completion pulse seen", int'(seqDone), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 clampEn after reset", int'(clampEn), 1);
    chk("R1 coreRstN after reset", int'(coreRstN), 0);
    chk("R1 porRstN after reset", int'(porRstN), 0);
    chk("R1 aa64Sel after reset", int'(aa64Sel), 0);
    chk("R1 dbgPwrUp after reset", int'(dbgPwrUp), 0);
    chk("R1 switch requests after reset", int'({swOnReq, swOffReq}), 0);
    chk("R1 busy/seqDone/powered after reset", int'({busy, seqDone, powered}), 0);
  endtask

  task automatic t_idle_ignore();
    logic [NOUT-1:0] snap;
    int busyBase;
    snap = outs; busyBase = riseCnt[O_BUSY];
    @(negedge clk);
    if (powered) upReq = 1'b1; else downReq = 1'b1;
    @(negedge clk);
    upReq = 1'b0; downReq = 1'b0;
    repeat (4) @(negedge clk);
    swDone = 1'b1;
    @(negedge clk);
    swDone = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 wrong idle command starts nothing", riseCnt[O_BUSY] - busyBase, 0);
    chk("R2 outputs unchanged after wrong command", int'(outs), int'(snap));
    chk("R8 stray switch-done while idle leaves outputs", int'(outs), int'(snap));
  endtask

  task automatic t_power_up(input int L, input int lat, input bit noisy);
    int s10, s20, e0, doneBase, busyBase;
    bit porWas, modeWas;
    s10 = 10 * (L + 1) + 2;
    s20 = 20 * (L + 1) + 2;
    unitLen = UW'(L); swLat = lat;
    porWas = porRstN; modeWas = aa64Sel;
    doneBase = riseCnt[O_DONE]; busyBase = riseCnt[O_BUSY];
    @(negedge clk); upReq = 1'b1;
    @(negedge clk); upReq = 1'b0;
    wait_done(noisy);
    e0 = riseCyc[O_BUSY];
    chk("R2 busy rises on acceptance edge", riseCnt[O_BUSY] - busyBase, 1);
    if (porWas) chk("R3 power-on reset asserted after core reset", fallCyc[O_POR] - e0, 1 + s10);
    if (!modeWas) chk("R4 width bit set before switch", riseCyc[O_MODE] - e0, 1 + 2 * s10);
    chk("R4 switch-on request start", riseCyc[O_SWON] - e0, 2 + 2 * s10);
    chk("R4 switch-on held until done", fallCyc[O_SWON] - riseCyc[O_SWON], lat + 1);
    chk("R3 clamp released after switch", fallCyc[O_CLAMP] - fallCyc[O_SWON], 1);
    chk("R6 long settle after clamp release", riseCyc[O_POR] - fallCyc[O_CLAMP], s20);
    chk("R3 core reset release spacing", riseCyc[O_CORE] - riseCyc[O_POR], s10);
    chk("R6 short settle before debug flag", riseCyc[O_DBG] - riseCyc[O_CORE], s10);
    chk("R9 done after debug settle", riseCyc[O_DONE] - riseCyc[O_DBG], s10 - 1);
    chk("R9 busy falls with done", fallCyc[O_BUSY] - riseCyc[O_DONE], 0);
    chk("R9 powered rises with done", riseCyc[O_PWR] - riseCyc[O_DONE], 0);
    chk("R9 done pulse width", fallCyc[O_DONE] - riseCyc[O_DONE], 1);
    chk("R3 final levels core/por/mode/clamp/dbg/powered",
        int'({coreRstN, porRstN, aa64Sel, clampEn, dbgPwrUp, powered}), 6'b111011);
    if (noisy) begin
      chk("R7 busy-time commands: one completion", riseCnt[O_DONE] - doneBase, 1);
      chk("R7 busy-time commands: one busy period", riseCnt[O_BUSY] - busyBase, 1);
      chk("R8 stray switch-done kept switch timing", riseCyc[O_SWON] - e0, 2 + 2 * s10);
    end
  endtask

  task automatic t_power_down(input int L, input int lat);
    int s10, s20, e0;
    s10 = 10 * (L + 1) + 2;
    s20 = 20 * (L + 1) + 2;
    unitLen = UW'(L); swLat = lat;
    @(negedge clk); downReq = 1'b1;
    @(negedge clk); downReq = 1'b0;
    wait_done(1'b0);
    e0 = riseCyc[O_BUSY];
    chk("R5 debug flag drops first", fallCyc[O_DBG] - e0, 1);
    chk("R5 clamp applied after debug settle", riseCyc[O_CLAMP] - fallCyc[O_DBG], s10);
    chk("R6 long settle after clamp apply", fallCyc[O_CORE] - riseCyc[O_CLAMP], s20);
    chk("R5 switch-off request after core reset", riseCyc[O_SWOFF] - fallCyc[O_CORE], s10);
    chk("R5 switch-off held until done", fallCyc[O_SWOFF] - riseCyc[O_SWOFF], lat + 1);
    chk("R9 done on switch-done edge", riseCyc[O_DONE] - fallCyc[O_SWOFF], 0);
    chk("R9 powered falls with done", fallCyc[O_PWR] - riseCyc[O_DONE], 0);
    chk("R5 final levels core/por/mode/clamp/dbg/powered",
        int'({coreRstN, porRstN, aa64Sel, clampEn, dbgPwrUp, powered}), 6'b011100);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R1-related run hung: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_power_up(1, 3, 1'b0);
    t_idle_ignore();
    t_power_down(0, 0);
    t_power_up(2, 5, 1'b1);
    t_power_down(1, 2);
    t_power_up(0, 1, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule